// File: doc/BRIEF.md
# Task-Driven Timer/Counter with Compare and Capture

This block is a free-running timer or event counter. Single-cycle task strobes start, stop, clear, shut it down, advance it, or copy its value into a channel register. A small word-addressed register port sets it up. In timer mode the count advances on a tick derived from the core clock through a power-of-two prescaler. In counter mode it advances once for each count strobe. The count width can be chosen at run time as 8, 16, 24 or 32 bits.

Each compare/capture channel holds a value. When an increment makes the masked count equal to that value, the channel sets its event flag and emits a one-cycle pulse. Per-channel shortcuts can then zero the count or halt it. A channel can be placed in one-shot mode, where it fires at most once per write to its value register. A level interrupt output is high while any enabled event flag is set. Software clears an event by writing zero to its flag.

Top module: `evt_timer`

Register map (word index on `addr_i`): 0 mode (bit 0: 0 timer, 1 counter), 1 width (2 bits: 0 = 16-bit, 1 = 8-bit, 2 = 24-bit, 3 = 32-bit), 2 prescaler (4 bits), 3 interrupt-enable set, 4 interrupt-enable clear, 5 compare-clears-count shortcut mask, 6 compare-stops-count shortcut mask, 7 one-shot enable mask, 8+n value register of channel n, 16+n event flag of channel n (bit 0). Channel n always maps to bit n of every mask.

## Requirements
- R1: The width field masks the count: codes 0/1/2/3 select 16/8/24/32 bits, and an increment past the all-ones value of the selected width gives zero.
- R2: In timer mode (mode bit 0) the running count advances once every 2^P core clocks, where P is the prescaler value. The first advance comes 2^P clocks after the edge that accepts START.
- R3: In counter mode (mode bit 1) each accepted count strobe adds one while running. A count strobe has no effect in timer mode or while stopped.
- R4: STOP freezes the count and keeps its value, and a later START resumes from that value. START while running has no effect.
- R5: CLEAR zeroes the count and leaves the run state unchanged. SHUTDOWN halts the block and zeroes the count.
- R6: A capture strobe on channel n loads that channel's value register with the count masked to the current width.
- R7: An increment that lands on the masked value of channel n sets event flag n. On the same edge it drives `cmp_pulse_o[n]` high for exactly one cycle.
- R8: On a channel hit, a set compare-clears bit for that channel makes the count zero instead of the matched value. A set compare-stops bit halts the counter. Both may apply together.
- R9: With one-shot set for channel n, the channel produces at most one hit after each write to its value register, and that write re-arms it. After reset the channel is not armed.
- R10: A write to the enable-set register ORs bits into the interrupt enable, and a write to the enable-clear register removes bits. The set register reads back the enable. The clear register reads zero.
- R11: `irq_o` is high exactly while some event flag and its enable bit are both set. Writing 0 to an event flag clears it, and writing 1 sets it.
- R12: When several strobes arrive in one cycle, only the highest-priority one acts, in the order SHUTDOWN, STOP, CLEAR, START, COUNT, CAPTURE.
- R13: A prescaler write above 9 stores 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | AW | Register word index |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| task_start_i | input | 1 | Start strobe |
| task_stop_i | input | 1 | Stop strobe |
| task_count_i | input | 1 | Count strobe (counter mode) |
| task_clear_i | input | 1 | Clear strobe |
| task_shutdown_i | input | 1 | Shutdown strobe |
| task_capture_i | input | NCH | Per-channel capture strobes |
| cmp_pulse_o | output | NCH | Per-channel one-cycle compare pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
A fault in the run flag or the count shows up at the first capture read after it occurs. It also appears as a missing or misplaced compare pulse one edge after the increment that should have matched. A prescaler divider that drifts moves every timer-mode sample by a whole tick, so a capture taken after a fixed number of clocks exposes it within 2^P cycles. A wrong one-shot arm bit or shortcut mask shows on the pulse output at the next matching increment. Enable and event state show on `irq_o` on the cycle after the register write.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W = 32;
  localparam int PS_W  = 4;
  localparam int PS_MAX = 9;

  localparam int A_MODE  = 0;
  localparam int A_WIDTH = 1;
  localparam int A_PRESC = 2;
  localparam int A_INTSET = 3;
  localparam int A_INTCLR = 4;
  localparam int A_SCCLR = 5;
  localparam int A_SCSTOP = 6;
  localparam int A_ONESHOT = 7;
  localparam int A_CC = 8;
  localparam int A_EV = 16;

  typedef enum logic [1:0] {
    W16 = 2'd0,
    W8  = 2'd1,
    W24 = 2'd2,
    W32 = 2'd3
  } width_e;

  function automatic logic [CNT_W-1:0] width_mask(width_e w);
    case (w)
      W16:     return 32'h0000_FFFF;
      W8:      return 32'h0000_00FF;
      W24:     return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/evt_tmr_presc.sv
module evt_tmr_presc
  import evt_timer_pkg::*;
#(
  parameter int DIV_W = PS_MAX
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] presc_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   lim;

  assign lim    = ({{DIV_W{1'b0}}, 1'b1} << presc_i) - 1'b1;
  assign tick_o = en_i & ({1'b0, div_q} == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (restart_i || tick_o) div_q <= '0;
    else if (en_i)              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/evt_tmr_chan.sv
module evt_tmr_chan
  import evt_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] inc_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic             oneshot_i,
  input  logic             cap_i,
  input  logic             cc_we_i,
  input  logic             ev_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cc_o,
  output logic             ev_o
);
  logic [CNT_W-1:0] cc_q;
  logic             armed_q, ev_q;

  assign hit_o = adv_i & (inc_i == (cc_q & mask_i)) & (~oneshot_i | armed_q);
  assign cc_o  = cc_q;
  assign ev_o  = ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q    <= '0;
      armed_q <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      if (cc_we_i)    cc_q <= wdata_i;
      else if (cap_i) cc_q <= cnt_i & mask_i;
      // write re-arms even on a same-cycle hit
      if (cc_we_i)    armed_q <= 1'b1;
      else if (hit_o) armed_q <= 1'b0;
      if (hit_o)        ev_q <= 1'b1;
      else if (ev_we_i) ev_q <= wdata_i[0];
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             task_start_i,
  input  logic             task_stop_i,
  input  logic             task_count_i,
  input  logic             task_clear_i,
  input  logic             task_shutdown_i,
  input  logic [NCH-1:0]   task_capture_i,
  output logic [NCH-1:0]   cmp_pulse_o,
  output logic             irq_o
);
  logic             mode_q, run_q;
  width_e           width_q;
  logic [PS_W-1:0]  presc_q;
  logic [NCH-1:0]   inten_q, sc_clr_q, sc_stop_q, oneshot_q, pulse_q;
  logic [CNT_W-1:0] cnt_q, inc, mask;
  logic [NCH-1:0]   hit, ev_vec, cap, cc_we, ev_we;
  logic [CNT_W-1:0] cc_arr [NCH];
  logic             hi, do_start, do_count, tick, adv, restart;

  // single winner: shutdown > stop > clear > start > count > capture
  assign hi       = task_shutdown_i | task_stop_i | task_clear_i;
  assign do_start = task_start_i & ~hi;
  assign do_count = task_count_i & ~hi & ~task_start_i;
  assign cap      = task_capture_i & {NCH{~(hi | task_start_i | task_count_i)}};

  assign mask    = width_mask(width_q);
  assign inc     = (cnt_q + CNT_W'(1)) & mask;
  assign restart = task_shutdown_i | (task_clear_i & ~task_stop_i) | (do_start & ~run_q);
  assign adv     = run_q & ~hi & (mode_q ? do_count : tick);

  evt_tmr_presc u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (run_q & ~mode_q),
    .restart_i(restart),
    .presc_i  (presc_q),
    .tick_o   (tick)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign cc_we[n] = we_i && (addr_i == AW'(A_CC + n));
    assign ev_we[n] = we_i && (addr_i == AW'(A_EV + n));
    evt_tmr_chan u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .inc_i    (inc),
      .cnt_i    (cnt_q),
      .mask_i   (mask),
      .oneshot_i(oneshot_q[n]),
      .cap_i    (cap[n]),
      .cc_we_i  (cc_we[n]),
      .ev_we_i  (ev_we[n]),
      .wdata_i  (wdata_i),
      .hit_o    (hit[n]),
      .cc_o     (cc_arr[n]),
      .ev_o     (ev_vec[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      pulse_q <= hit;
      if (task_shutdown_i) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (task_stop_i) begin
        run_q <= 1'b0;
      end else if (task_clear_i) begin
        cnt_q <= '0;
      end else begin
        if (do_start) run_q <= 1'b1;
        if (adv) begin
          cnt_q <= (|(hit & sc_clr_q)) ? '0 : inc;
          if (|(hit & sc_stop_q)) run_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 1'b0;
      width_q   <= W16;
      presc_q   <= '0;
      inten_q   <= '0;
      sc_clr_q  <= '0;
      sc_stop_q <= '0;
      oneshot_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        AW'(A_MODE):    mode_q    <= wdata_i[0];
        AW'(A_WIDTH):   width_q   <= width_e'(wdata_i[1:0]);
        AW'(A_PRESC):   presc_q   <= (wdata_i[PS_W-1:0] > PS_W'(PS_MAX)) ? PS_W'(PS_MAX)
                                                                       : wdata_i[PS_W-1:0];
        AW'(A_INTSET):  inten_q   <= inten_q | wdata_i[NCH-1:0];
        AW'(A_INTCLR):  inten_q   <= inten_q & ~wdata_i[NCH-1:0];
        AW'(A_SCCLR):   sc_clr_q  <= wdata_i[NCH-1:0];
        AW'(A_SCSTOP):  sc_stop_q <= wdata_i[NCH-1:0];
        AW'(A_ONESHOT): oneshot_q <= wdata_i[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(A_MODE):    rdata_o = CNT_W'(mode_q);
      AW'(A_WIDTH):   rdata_o = CNT_W'(width_q);
      AW'(A_PRESC):   rdata_o = CNT_W'(presc_q);
      AW'(A_INTSET):  rdata_o = CNT_W'(inten_q);
      AW'(A_SCCLR):   rdata_o = CNT_W'(sc_clr_q);
      AW'(A_SCSTOP):  rdata_o = CNT_W'(sc_stop_q);
      AW'(A_ONESHOT): rdata_o = CNT_W'(oneshot_q);
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == AW'(A_CC + n)) rdata_o = cc_arr[n];
      if (addr_i == AW'(A_EV + n)) rdata_o = CNT_W'(ev_vec[n]);
    end
  end

  assign cmp_pulse_o = pulse_q;
  assign irq_o       = |(ev_vec & inten_q);
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             task_stop_i,
  input logic             task_clear_i,
  input logic             task_shutdown_i,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [NCH-1:0]   ev_vec,
  input logic [NCH-1:0]   inten_q,
  input logic [NCH-1:0]   cmp_pulse_o
);
  p_shutdown_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_shutdown_i |=> (!run_q && cnt_q == '0));

  p_stop_halts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_stop_i |=> !run_q);

  p_stopped_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !task_clear_i && !task_shutdown_i) |=> $stable(cnt_q));

  p_inten_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(A_INTCLR)) |=> ((inten_q & $past(wdata_i[NCH-1:0])) == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_a
    p_pulse_sets_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_pulse_o[n] |-> ev_vec[n]);
  end
endmodule

bind evt_timer evt_timer_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .task_stop_i    (task_stop_i),
  .task_clear_i   (task_clear_i),
  .task_shutdown_i(task_shutdown_i),
  .run_q          (run_q),
  .cnt_q          (cnt_q),
  .ev_vec         (ev_vec),
  .inten_q        (inten_q),
  .cmp_pulse_o    (cmp_pulse_o)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  localparam int NCH = 4;
  localparam int AW  = 5;
  localparam logic [4:0] S_COUNT = 5'd1, S_START = 5'd2, S_CLEAR = 5'd4,
                         S_STOP = 5'd8, S_SHUT = 5'd16;
  localparam int A_MODE = 0, A_WIDTH = 1, A_PRESC = 2, A_INTSET = 3, A_INTCLR = 4,
                 A_SCCLR = 5, A_SCSTOP = 6, A_ONESHOT = 7, A_CC = 8, A_EV = 16;

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic t_start = 0, t_stop = 0, t_count = 0, t_clear = 0, t_shut = 0;
  logic [NCH-1:0] t_cap = '0, pulse;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  evt_timer #(.NCH(NCH), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .task_start_i(t_start), .task_stop_i(t_stop),
    .task_count_i(t_count), .task_clear_i(t_clear), .task_shutdown_i(t_shut),
    .task_capture_i(t_cap), .cmp_pulse_o(pulse), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); addr = AW'(a); #1 d = rdata;
  endtask

  task automatic strobe(logic [4:0] s, logic [NCH-1:0] c);
    @(negedge clk);
    {t_shut, t_stop, t_clear, t_start, t_count} = s; t_cap = c;
    @(negedge clk);
    {t_shut, t_stop, t_clear, t_start, t_count} = '0; t_cap = '0;
  endtask

  task automatic count_n(int n);
    @(negedge clk); t_count = 1;
    repeat (n) @(negedge clk);
    t_count = 0;
  endtask

  task automatic cap_rd(int ch, output logic [31:0] d);
    strobe('0, NCH'(1) << ch);
    rd(A_CC + ch, d);
  endtask

  task automatic setup(logic m, logic [1:0] w);
    strobe(S_SHUT, '0);
    wr(A_MODE, 32'(m));
    wr(A_WIDTH, 32'(w));
  endtask

  task automatic park_cc();
    for (int n = 0; n < NCH; n++) wr(A_CC + n, 32'hFFFF_0000);
  endtask

  task automatic t_reset();
    chk("R11 irq after reset", 32'(irq), 0);
    chk("R7 pulse after reset", 32'(pulse), 0);
    rd(A_INTSET, v); chk("R10 enable after reset", v, 0);
    rd(A_CC, v); chk("R6 cc0 after reset", v, 0);
  endtask

  task automatic t_timer();
    setup(1'b0, 2'd3);
    wr(A_PRESC, 32'd15);
    rd(A_PRESC, v); chk("R13 prescaler saturates", v, 9);
    wr(A_PRESC, 32'd2);
    @(negedge clk); t_start = 1;
    @(negedge clk); t_start = 0;
    repeat (16) @(negedge clk);
    t_stop = 1;
    @(negedge clk); t_stop = 0;
    cap_rd(0, v); chk("R2 timer ticks at 2^P", v, 4);
    repeat (10) @(negedge clk);
    cap_rd(0, v); chk("R4 stopped count frozen", v, 4);
  endtask

  task automatic t_count_in_timer();
    setup(1'b0, 2'd3);
    wr(A_PRESC, 32'd9);
    strobe(S_START, '0);
    count_n(5);
    cap_rd(0, v); chk("R3 count ignored in timer mode", v, 0);
    strobe(S_SHUT, '0);
  endtask

  task automatic t_wrap();
    setup(1'b1, 2'd1);
    strobe(S_START, '0);
    count_n(259);
    cap_rd(0, v); chk("R1 8-bit wrap", v, 3);
  endtask

  task automatic t_capmask();
    setup(1'b1, 2'd3);
    strobe(S_START, '0);
    count_n(261);
    cap_rd(1, v); chk("R6 capture 32-bit", v, 32'h105);
    wr(A_WIDTH, 32'd1);
    cap_rd(1, v); chk("R6 capture masked to 8 bits", v, 32'h05);
    wr(A_WIDTH, 32'd0);
    cap_rd(1, v); chk("R6 capture masked to 16 bits", v, 32'h105);
  endtask

  task automatic t_compare();
    setup(1'b1, 2'd3);
    park_cc();
    wr(A_CC + 1, 32'd3);
    strobe(S_START, '0);
    strobe(S_COUNT, '0);
    strobe(S_COUNT, '0);
    chk("R7 no pulse before match", 32'(pulse), 0);
    strobe(S_COUNT, '0);
    chk("R7 pulse on match", 32'(pulse), 32'b0010);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", 32'(pulse), 0);
    rd(A_EV + 1, v); chk("R7 event flag set", v, 1);
  endtask

  task automatic t_irq();
    wr(A_EV + 0, 32'd1);
    @(negedge clk); chk("R11 irq low while disabled", 32'(irq), 0);
    wr(A_INTSET, 32'd2);
    chk("R11 irq high on enabled event", 32'(irq), 1);
    wr(A_EV + 1, 32'd0);
    chk("R11 irq drops when event cleared", 32'(irq), 0);
    wr(A_INTCLR, 32'hF);
    wr(A_EV + 0, 32'd0);
  endtask

  task automatic t_inten();
    wr(A_INTSET, 32'd6);
    rd(A_INTSET, v); chk("R10 set ORs bits", v, 6);
    wr(A_INTCLR, 32'd2);
    rd(A_INTSET, v); chk("R10 clear removes bits", v, 4);
    rd(A_INTCLR, v); chk("R10 clear reads zero", v, 0);
    wr(A_INTCLR, 32'hF);
  endtask

  task automatic t_resume();
    setup(1'b1, 2'd3);
    strobe(S_START, '0);
    count_n(3);
    strobe(S_STOP, '0);
    count_n(2);
    cap_rd(0, v); chk("R3 count ignored while stopped", v, 3);
    strobe(S_START, '0);
    count_n(1);
    cap_rd(0, v); chk("R4 resume from held value", v, 4);
    strobe(S_START, '0);
    count_n(1);
    cap_rd(0, v); chk("R4 start while running no effect", v, 5);
  endtask

  task automatic t_shortcuts();
    setup(1'b1, 2'd3);
    park_cc();
    wr(A_CC + 0, 32'd2);
    wr(A_SCCLR, 32'd1);
    strobe(S_START, '0);
    count_n(2);
    chk("R8 pulse with clear shortcut", 32'(pulse), 32'b0001);
    cap_rd(3, v); chk("R8 clear shortcut zeroes", v, 0);
    count_n(1);
    cap_rd(3, v); chk("R8 still running after clear shortcut", v, 1);
    wr(A_SCCLR, 32'd0);
    wr(A_SCSTOP, 32'd4);
    wr(A_CC + 2, 32'd3);
    count_n(2);
    count_n(1);
    cap_rd(3, v); chk("R8 stop shortcut halts", v, 3);
    wr(A_SCSTOP, 32'd0);
  endtask

  task automatic t_oneshot();
    setup(1'b1, 2'd3);
    park_cc();
    wr(A_ONESHOT, 32'd8);
    wr(A_CC + 3, 32'd1);
    strobe(S_START, '0);
    strobe(S_COUNT, '0);
    chk("R9 first one-shot hit", 32'(pulse), 32'b1000);
    strobe(S_CLEAR, '0);
    strobe(S_COUNT, '0);
    chk("R9 no second hit without rearm", 32'(pulse), 0);
    wr(A_CC + 3, 32'd1);
    strobe(S_CLEAR, '0);
    strobe(S_COUNT, '0);
    chk("R9 rearmed by value write", 32'(pulse), 32'b1000);
    wr(A_ONESHOT, 32'd0);
  endtask

  task automatic t_clear_shut();
    strobe(S_COUNT, '0);
    strobe(S_CLEAR, '0);
    strobe(S_COUNT, '0);
    cap_rd(0, v); chk("R5 clear keeps running", v, 1);
    strobe(S_SHUT, '0);
    strobe(S_COUNT, '0);
    cap_rd(0, v); chk("R5 shutdown stops and zeroes", v, 0);
  endtask

  task automatic t_priority();
    setup(1'b1, 2'd3);
    park_cc();
    strobe(S_START, '0);
    count_n(5);
    strobe(S_CLEAR | S_COUNT, '0);
    cap_rd(0, v); chk("R12 clear beats count", v, 0);
    strobe(S_STOP | S_START, '0);
    strobe(S_COUNT, '0);
    cap_rd(0, v); chk("R12 stop beats start", v, 0);
    strobe(S_START, '0);
    count_n(2);
    strobe(S_COUNT, 4'b0010);
    rd(A_CC + 1, v); chk("R12 count beats capture", v, 32'hFFFF_0000);
    cap_rd(0, v); chk("R12 count applied", v, 3);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_count_in_timer();
    t_wrap();
    t_capmask();
    t_compare();
    t_irq();
    t_inten();
    t_resume();
    t_shortcuts();
    t_oneshot();
    t_clear_shut();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule